// File: doc/BRIEF.md
# PLL Control Register Bank

This block holds the control state of a clock synthesizer in four small registers and drives the synthesizer's control pins straight from them. These pins are the pre-divider, the post-divider, the feedback multiplier, the loop bandwidth trim, a reset, a power-down and a bypass. Software writes through a single-cycle port that carries an address, a 32-bit word and a write strobe. The upper half of each word is a per-bit enable for the lower half, so single bits can be changed with no read-modify-write.

From a reference-frequency input the block also computes, one cycle after any change, the frequency the synthesizer is expected to produce. When bypass is set, that frequency is simply the reference. An enable flag shows whether the synthesizer is powered. Reading an address returns the stored 16-bit content one cycle later.

Top module: `pllc_top`

## Requirements
- R1: Register n is at byte address 4*n (n = 0..3). The rdata output shows the 16 stored bits of the addressed register one clock after the address is presented.
- R2: On a write, stored bit i (0..15) takes wdata[i] only when wdata[16+i] is 1. Every other bit keeps its value, and a write whose upper half is zero changes nothing.
- R3: After reset, registers 0, 1 and 2 read 0 and register 3 reads 0x0002. So power-down is 1, and reset, bypass and every divider field are 0.
- R4: Register 0 bits 3:0 drive post_div and bits 13:8 drive pre_div.
- R5: Register 1 bits 12:0 drive fb_mult, and register 2 bits 11:0 drive bw_trim.
- R6: Register 3 drives three pins: bit 5 drives pll_rst, bit 1 drives pll_pd and bit 0 drives pll_byp.
- R7: pll_on is 1 exactly when pll_pd is 0.
- R8: With bypass clear, out_freq = ((ref_freq*(fb_mult+1)) / (pre_div+1)) / (post_div+1). Both divisions truncate, the product is computed without overflow, and the result appears one clock after the inputs.
- R9: With bypass set, out_freq equals ref_freq one clock later, whatever the divider fields hold.
- R10: A write whose address has bit 1 or bit 0 set, or that lies above the last register, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe |
| addr | input | 4 | Byte address for writes and reads |
| wdata | input | 32 | Bits 31:16 are the bit enables; bits 15:0 are the data |
| rdata | output | 16 | Registered read-back of the addressed register |
| ref_freq | input | 32 | Reference frequency |
| out_freq | output | 45 | Computed output frequency |
| pre_div | output | 6 | Input divider field |
| post_div | output | 4 | Output divider field |
| fb_mult | output | 13 | Feedback multiplier field |
| bw_trim | output | 12 | Bandwidth adjust field |
| pll_rst | output | 1 | Synthesizer reset |
| pll_pd | output | 1 | Synthesizer power-down |
| pll_byp | output | 1 | Bypass |
| pll_on | output | 1 | Enabled status |

## Verification
The hardest case to reach is the largest product: a full-scale reference times the largest multiplier with unity dividers. Only there does a narrow intermediate overflow. The bench sets the multiplier through a full-mask write to register 1 and drives ref_freq to all ones. A second hard case is the sequential truncation with both dividers at their maximum, where the result collapses to zero. Partial-mask and misaligned writes are each followed by a read-back, so the bits they must leave alone are observed directly.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int NREG    = 4;
  localparam int HALF_W  = 16;
  localparam int IDX_W   = $clog2(NREG);
  // register 0 fields
  localparam int POST_LSB = 0;
  localparam int POST_W   = 4;
  localparam int PRE_LSB  = 8;
  localparam int PRE_W    = 6;
  // register 1 / 2 fields
  localparam int MULT_W   = 13;
  localparam int BW_W     = 12;
  // register 3 control bits
  localparam int BIT_BYP  = 0;
  localparam int BIT_PD   = 1;
  localparam int BIT_RST  = 5;

  function automatic logic [HALF_W-1:0] reset_value(input int idx);
    logic [HALF_W-1:0] v;
    v = '0;
    if (idx == 3) v[BIT_PD] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pllc_regfile.sv
module pllc_regfile
  import pllc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [2*HALF_W-1:0]            wdata,
  output logic [NREG-1:0][HALF_W-1:0]    regs,
  output logic [HALF_W-1:0]              rdata
);
  localparam int LOW_W = IDX_W + 2;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [HALF_W-1:0] en_bits;
  logic [HALF_W-1:0] new_bits;

  assign idx      = addr[LOW_W-1:2];
  assign in_range = ((addr >> LOW_W) == '0) && (addr[1:0] == 2'b00);
  assign en_bits  = wdata[2*HALF_W-1:HALF_W];
  assign new_bits = wdata[HALF_W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we && in_range && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= reset_value(g);
      else if (hit)
        regs[g] <= (regs[g] & ~en_bits) | (new_bits & en_bits);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if ((addr >> LOW_W) == '0)
      rdata <= regs[idx];
    else
      rdata <= '0;
  end

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we && en_bits == '0) |=> $stable(regs));

  // R10
  misalign_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr[1:0] != 2'b00) |=> $stable(regs));

  // R3
  rst_val_chk: assert property (@(posedge clk)
    $past(rst) |-> (regs[0] == '0 && regs[1] == '0 && regs[2] == '0 &&
                    regs[3] == reset_value(3)));
endmodule

// File: rtl/pllc_freq_calc.sv
module pllc_freq_calc
  import pllc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int OUT_W  = FREQ_W + MULT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] ref_freq,
  input  logic [MULT_W-1:0] mult,
  input  logic [PRE_W-1:0]  pre,
  input  logic [POST_W-1:0] post,
  input  logic              byp,
  output logic [OUT_W-1:0]  freq
);
  localparam int PROD_W = FREQ_W + MULT_W + 1;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] step1;
  logic [PROD_W-1:0] step2;

  always_comb begin
    prod  = PROD_W'(ref_freq) * (PROD_W'(mult) + PROD_W'(1));
    step1 = prod / (PROD_W'(pre) + PROD_W'(1));
    step2 = step1 / (PROD_W'(post) + PROD_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)
      freq <= '0;
    else if (byp)
      freq <= OUT_W'(ref_freq);
    else
      freq <= step2[OUT_W-1:0];
  end

  // R9
  byp_pass_chk: assert property (@(posedge clk) disable iff (rst)
    byp |=> (freq == OUT_W'($past(ref_freq))));

  // R8
  unity_chk: assert property (@(posedge clk) disable iff (rst)
    (!byp && mult == '0 && pre == '0 && post == '0) |=> (freq == OUT_W'($past(ref_freq))));
endmodule

// File: rtl/pllc_top.sv
module pllc_top
  import pllc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FREQ_W = 32,
  parameter int OUT_W  = FREQ_W + pllc_pkg::MULT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [FREQ_W-1:0] ref_freq,
  output logic [OUT_W-1:0]  out_freq,
  output logic [5:0]        pre_div,
  output logic [3:0]        post_div,
  output logic [12:0]       fb_mult,
  output logic [11:0]       bw_trim,
  output logic              pll_rst,
  output logic              pll_pd,
  output logic              pll_byp,
  output logic              pll_on
);
  logic [NREG-1:0][HALF_W-1:0] regs;

  pllc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .regs  (regs),
    .rdata (rdata)
  );

  assign post_div = regs[0][POST_LSB +: POST_W];
  assign pre_div  = regs[0][PRE_LSB +: PRE_W];
  assign fb_mult  = regs[1][MULT_W-1:0];
  assign bw_trim  = regs[2][BW_W-1:0];
  assign pll_rst  = regs[3][BIT_RST];
  assign pll_pd   = regs[3][BIT_PD];
  assign pll_byp  = regs[3][BIT_BYP];
  assign pll_on   = ~regs[3][BIT_PD];

  pllc_freq_calc #(.FREQ_W(FREQ_W), .OUT_W(OUT_W)) u_calc (
    .clk      (clk),
    .rst      (rst),
    .ref_freq (ref_freq),
    .mult     (fb_mult),
    .pre      (pre_div),
    .post     (post_div),
    .byp      (pll_byp),
    .freq     (out_freq)
  );

  // R7
  on_pd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_pd) |-> $fell(pll_on));
endmodule

// File: tb/sim_pllc_top.sv
module sim_pllc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] ref_freq = '0;
  logic [44:0] out_freq;
  logic [5:0]  pre_div;
  logic [3:0]  post_div;
  logic [12:0] fb_mult;
  logic [11:0] bw_trim;
  logic        pll_rst, pll_pd, pll_byp, pll_on;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pllc_top u0 (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ref_freq(ref_freq), .out_freq(out_freq), .pre_div(pre_div),
    .post_div(post_div), .fb_mult(fb_mult), .bw_trim(bw_trim),
    .pll_rst(pll_rst), .pll_pd(pll_pd), .pll_byp(pll_byp), .pll_on(pll_on)
  );

  typedef struct packed {
    logic [31:0] rf;
    logic [12:0] nf;
    logic [5:0]  nr;
    logic [3:0]  no;
    logic        byp;
    logic [63:0] expv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'd24000000, 13'd99,   6'd1,  4'd1,  1'b0, 64'd600000000},
    '{32'd24000000, 13'd0,    6'd0,  4'd0,  1'b0, 64'd24000000},
    '{32'd1000,     13'd2,    6'd6,  4'd2,  1'b0, 64'd142},
    '{32'hFFFFFFFF, 13'd8191, 6'd0,  4'd0,  1'b0, 64'd35184372080640},
    '{32'd1000,     13'd0,    6'd63, 4'd15, 1'b0, 64'd0},
    '{32'd12345,    13'd99,   6'd1,  4'd1,  1'b1, 64'd12345}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    we = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    check("R3 pd", 64'(pll_pd), 64'd1);
    check("R7 on", 64'(pll_on), 64'd0);
    check("R3 fields", {pre_div, post_div, fb_mult, bw_trim, pll_rst, pll_byp}, 64'd0);
    rd(4'hC, v); check("R3 reg3", 64'(v), 64'h0002);
    rd(4'h0, v); check("R3 reg0", 64'(v), 64'h0000);

    // R8 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      ref_freq = VECS[i].rf;
      wr(4'h4, {16'hFFFF, 3'b000, VECS[i].nf});
      wr(4'h0, {16'hFFFF, 2'b00, VECS[i].nr, 4'b0000, VECS[i].no});
      wr(4'hC, {16'h0001, 15'd0, VECS[i].byp});
      @(negedge clk);
      check(VECS[i].byp ? "R9 bypass freq" : "R8 freq", 64'(out_freq), VECS[i].expv);
    end

    // R4 R1 register 0 fields and readback
    wr(4'h0, 32'hFFFF_3F0F);
    check("R4 pre_div", 64'(pre_div), 64'd63);
    check("R4 post_div", 64'(post_div), 64'd15);
    rd(4'h0, v); check("R1 reg0 read", 64'(v), 64'h3F0F);

    // R5 R2 masked writes on register 2
    wr(4'h8, 32'hFFFF_0ABC);
    check("R5 bw_trim", 64'(bw_trim), 64'hABC);
    wr(4'h8, 32'h00F0_0000);
    check("R2 partial clear", 64'(bw_trim), 64'hA0C);
    wr(4'h8, 32'h0000_FFFF);
    rd(4'h8, v); check("R2 zero mask", 64'(v), 64'h0A0C);
    wr(4'h4, 32'hFFFF_1234);
    check("R5 fb_mult", 64'(fb_mult), 64'h1234);

    // R6 R7 control bits
    wr(4'hC, 32'h0023_0021);
    check("R6 rst", 64'(pll_rst), 64'd1);
    check("R6 pd", 64'(pll_pd), 64'd0);
    check("R6 byp", 64'(pll_byp), 64'd1);
    check("R7 on", 64'(pll_on), 64'd1);
    wr(4'hC, 32'h0002_0002);
    check("R7 off", 64'(pll_on), 64'd0);
    rd(4'hC, v); check("R1 reg3 read", 64'(v), 64'h0023);

    // R10 misaligned writes ignored
    wr(4'h1, 32'hFFFF_0000);
    wr(4'h6, 32'hFFFF_0000);
    rd(4'h0, v); check("R10 reg0 kept", 64'(v), 64'h3F0F);
    rd(4'h4, v); check("R10 reg1 kept", 64'(v), 64'h1234);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule